// File: doc/BRIEF.md
# Register Bridge to a Clock Synthesizer Configuration Port

This block is a memory-mapped slave on an AXI4-Lite bus (32-bit data, full-word writes). It lets a processor reach the 16-bit configuration registers of a clock-synthesis primitive through that primitive's configuration port. The port uses a one-cycle enable strobe, a write-enable, a 7-bit register address, 16-bit write data, 16-bit read data and a ready strobe.

Software launches one access by writing one control word. That word carries a launch flag, a direction flag, the target register address and the write data. While the access is outstanding, a busy flag in a status word is high. When a read completes, the low half of the status word holds the returned data. A separate reset register drives two level outputs: one takes the core out of reset and one enables the clock manager. Only one configuration access can be in flight at a time.

Top module: `cfg_port_bridge`

## Requirements
- R1: After reset, every register is clear. The configuration-port strobes, `core_run_o` and `clk_en_o` are low, and reads of offsets 0x40 and 0x74 return zero.
- R2: An accepted write to offset 0x70 with bit 29 set and bit 28 clear starts a configuration write. One cycle after the bus write is accepted, `cfg_en_o` and `cfg_we_o` are high, `cfg_addr_o` equals control bits 22:16 and `cfg_wdata_o` equals control bits 15:0. Control bits 31:30 and 27:23 have no effect.
- R3: Status bit 16 (busy) reads as one from the cycle after a transaction is launched. It reads as zero again from the second cycle after `cfg_rdy_i` is seen high, meaning the bus read path returns the value that the status register held at the moment the read was accepted.
- R4: When a read transaction (bit 28 set) sees `cfg_rdy_i`, `cfg_rdata_i` is stored and returned in status bits 15:0. Write transactions leave that field unchanged.
- R5: A control write that arrives while busy is set starts nothing. It changes neither the port outputs nor the transaction already in flight.
- R6: A control write with bit 29 clear starts no transaction.
- R7: Offset 0x40 holds two bits. Bit 0 drives `core_run_o` and bit 1 drives `clk_en_o`, so writing 0x1 releases the core and leaves the clock manager off. The register reads back as those two bits with all other bits zero.
- R8: Offsets other than 0x40 and 0x74 read as zero. Writes to offsets other than 0x40 and 0x70 change no state. Address bits 1:0 are ignored.
- R9: Each accepted bus write gets exactly one OKAY response, and each accepted read gets exactly one OKAY data beat. Every response is held stable until its ready is high. A new request of the same kind is not accepted while a response is pending.
- R10: `cfg_en_o` is high for exactly one cycle per transaction. `cfg_we_o` is high only together with `cfg_en_o`. `cfg_addr_o` holds steady while the transaction is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| s_awaddr_i | input | AW | Write address |
| s_awvalid_i | input | 1 | Write address valid |
| s_awready_o | output | 1 | Write address ready |
| s_wdata_i | input | DW | Write data |
| s_wvalid_i | input | 1 | Write data valid |
| s_wready_o | output | 1 | Write data ready |
| s_bresp_o | output | 2 | Write response, always OKAY |
| s_bvalid_o | output | 1 | Write response valid |
| s_bready_i | input | 1 | Write response ready |
| s_araddr_i | input | AW | Read address |
| s_arvalid_i | input | 1 | Read address valid |
| s_arready_o | output | 1 | Read address ready |
| s_rdata_o | output | DW | Read data |
| s_rresp_o | output | 2 | Read response, always OKAY |
| s_rvalid_o | output | 1 | Read data valid |
| s_rready_i | input | 1 | Read data ready |
| cfg_en_o | output | 1 | One-cycle access strobe to the primitive |
| cfg_we_o | output | 1 | Write qualifier for the strobe |
| cfg_addr_o | output | CFG_AW | Configuration register address |
| cfg_wdata_o | output | CFG_DW | Configuration write data |
| cfg_rdata_i | input | CFG_DW | Configuration read data |
| cfg_rdy_i | input | 1 | Access complete strobe from the primitive |
| core_run_o | output | 1 | Core released from reset |
| clk_en_o | output | 1 | Clock manager enable |

## Verification
- **Bus handshakes.** The write and read ready signals are combinational. The response valids and the read data appear one cycle after acceptance.
- **Configuration-port strobes.** `cfg_en_o`, `cfg_we_o`, the address and the write data are registered, so they show up one cycle after the control write is accepted.
- **Busy flag and captured data.** Busy falls, and read data is captured, one cycle after `cfg_rdy_i`. A status read reports that change one further cycle later.
- **How the checks keep to this timing.** The bench model updates its state on the same clock edge as the design. It compares every output at the falling edge against that model, with the combinational readies derived from the current inputs. Directed checks then read results back through the bus with responder latencies of 1 to 20 cycles.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;
  localparam int unsigned OFF_RST  = 'h40;
  localparam int unsigned OFF_CTRL = 'h70;
  localparam int unsigned OFF_STAT = 'h74;

  localparam int unsigned SEL_BIT  = 29;
  localparam int unsigned RD_BIT   = 28;
  localparam int unsigned ADDR_LSB = 16;
  localparam int unsigned BUSY_BIT = 16;

  typedef enum logic [1:0] {REG_NONE, REG_RST, REG_CTRL, REG_STAT} reg_sel_e;
  typedef enum logic {ST_IDLE, ST_WAIT} seq_state_e;
endpackage

// File: rtl/cfgb_axil_port.sv
module cfgb_axil_port #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] s_awaddr_i,
  input  logic          s_awvalid_i,
  output logic          s_awready_o,
  input  logic [DW-1:0] s_wdata_i,
  input  logic          s_wvalid_i,
  output logic          s_wready_o,
  output logic [1:0]    s_bresp_o,
  output logic          s_bvalid_o,
  input  logic          s_bready_i,
  input  logic [AW-1:0] s_araddr_i,
  input  logic          s_arvalid_i,
  output logic          s_arready_o,
  output logic [DW-1:0] s_rdata_o,
  output logic [1:0]    s_rresp_o,
  output logic          s_rvalid_o,
  input  logic          s_rready_i,
  output logic          wr_stb_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic [DW-1:0] rd_data_i
);
  logic          bvalid_q, rvalid_q;
  logic [DW-1:0] rdata_q;
  logic          wacc, racc;

  // address and data taken together; one response outstanding per channel
  assign wacc = s_awvalid_i && s_wvalid_i && !bvalid_q;
  assign racc = s_arvalid_i && !rvalid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bvalid_q <= 1'b0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      if (wacc)            bvalid_q <= 1'b1;
      else if (s_bready_i) bvalid_q <= 1'b0;
      if (racc) begin
        rvalid_q <= 1'b1;
        rdata_q  <= rd_data_i;
      end else if (s_rready_i) begin
        rvalid_q <= 1'b0;
      end
    end
  end

  assign s_awready_o = wacc;
  assign s_wready_o  = wacc;
  assign s_bresp_o   = 2'b00;
  assign s_bvalid_o  = bvalid_q;
  assign s_arready_o = !rvalid_q;
  assign s_rdata_o   = rdata_q;
  assign s_rresp_o   = 2'b00;
  assign s_rvalid_o  = rvalid_q;

  assign wr_stb_o  = wacc;
  assign wr_addr_o = s_awaddr_i;
  assign wr_data_o = s_wdata_i;
  assign rd_addr_o = s_araddr_i;
endmodule

// File: rtl/cfgb_regs.sv
module cfgb_regs
  import cfgb_pkg::*;
#(
  parameter int AW     = 8,
  parameter int DW     = 32,
  parameter int CFG_AW = 7,
  parameter int CFG_DW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_stb_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [DW-1:0]     rd_data_o,
  input  logic              busy_i,
  input  logic [CFG_DW-1:0] cap_i,
  output logic              start_o,
  output logic              start_rd_o,
  output logic [CFG_AW-1:0] start_addr_o,
  output logic [CFG_DW-1:0] start_data_o,
  output logic              core_run_o,
  output logic              clk_en_o
);
  localparam int WW = AW - 2;

  function automatic reg_sel_e decode(input logic [AW-1:0] a);
    if (a[AW-1:2] == WW'(OFF_RST >> 2))  return REG_RST;
    if (a[AW-1:2] == WW'(OFF_CTRL >> 2)) return REG_CTRL;
    if (a[AW-1:2] == WW'(OFF_STAT >> 2)) return REG_STAT;
    return REG_NONE;
  endfunction

  reg_sel_e wr_sel, rd_sel;
  logic     run_q, clken_q;
  logic     unused_bits;

  assign wr_sel = decode(wr_addr_i);
  assign rd_sel = decode(rd_addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      clken_q <= 1'b0;
    end else if (wr_stb_i && wr_sel == REG_RST) begin
      run_q   <= wr_data_i[0];
      clken_q <= wr_data_i[1];
    end
  end

  assign start_o      = wr_stb_i && wr_sel == REG_CTRL && wr_data_i[SEL_BIT] && !busy_i;
  assign start_rd_o   = wr_data_i[RD_BIT];
  assign start_addr_o = wr_data_i[ADDR_LSB +: CFG_AW];
  assign start_data_o = wr_data_i[CFG_DW-1:0];

  always_comb begin
    rd_data_o = '0;
    case (rd_sel)
      REG_RST:  rd_data_o[1:0] = {clken_q, run_q};
      REG_STAT: begin
        rd_data_o[BUSY_BIT]     = busy_i;
        rd_data_o[CFG_DW-1:0]   = cap_i;
      end
      default:  rd_data_o = '0;
    endcase
  end

  assign core_run_o = run_q;
  assign clk_en_o   = clken_q;

  assign unused_bits = ^{wr_addr_i[1:0], rd_addr_i[1:0], wr_data_i[DW-1:SEL_BIT+1],
                         wr_data_i[RD_BIT-1:ADDR_LSB+CFG_AW]};
endmodule

// File: rtl/cfgb_seq.sv
module cfgb_seq
  import cfgb_pkg::*;
#(
  parameter int CFG_AW = 7,
  parameter int CFG_DW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              start_rd_i,
  input  logic [CFG_AW-1:0] start_addr_i,
  input  logic [CFG_DW-1:0] start_data_i,
  output logic              cfg_en_o,
  output logic              cfg_we_o,
  output logic [CFG_AW-1:0] cfg_addr_o,
  output logic [CFG_DW-1:0] cfg_wdata_o,
  input  logic [CFG_DW-1:0] cfg_rdata_i,
  input  logic              cfg_rdy_i,
  output logic              busy_o,
  output logic [CFG_DW-1:0] cap_o
);
  seq_state_e        state_q;
  logic              en_q, we_q, rd_q;
  logic [CFG_AW-1:0] addr_q;
  logic [CFG_DW-1:0] wdata_q, cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      en_q    <= 1'b0;
      we_q    <= 1'b0;
      rd_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      cap_q   <= '0;
    end else begin
      en_q <= 1'b0;
      we_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_WAIT;
          en_q    <= 1'b1;
          we_q    <= !start_rd_i;
          rd_q    <= start_rd_i;
          addr_q  <= start_addr_i;
          wdata_q <= start_data_i;
        end
        ST_WAIT: if (cfg_rdy_i) begin
          state_q <= ST_IDLE;
          if (rd_q) cap_q <= cfg_rdata_i;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cfg_en_o    = en_q;
  assign cfg_we_o    = we_q;
  assign cfg_addr_o  = addr_q;
  assign cfg_wdata_o = wdata_q;
  assign busy_o      = state_q == ST_WAIT;
  assign cap_o       = cap_q;
endmodule

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge #(
  parameter int AW     = 8,
  parameter int DW     = 32,
  parameter int CFG_AW = 7,
  parameter int CFG_DW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     s_awaddr_i,
  input  logic              s_awvalid_i,
  output logic              s_awready_o,
  input  logic [DW-1:0]     s_wdata_i,
  input  logic              s_wvalid_i,
  output logic              s_wready_o,
  output logic [1:0]        s_bresp_o,
  output logic              s_bvalid_o,
  input  logic              s_bready_i,
  input  logic [AW-1:0]     s_araddr_i,
  input  logic              s_arvalid_i,
  output logic              s_arready_o,
  output logic [DW-1:0]     s_rdata_o,
  output logic [1:0]        s_rresp_o,
  output logic              s_rvalid_o,
  input  logic              s_rready_i,
  output logic              cfg_en_o,
  output logic              cfg_we_o,
  output logic [CFG_AW-1:0] cfg_addr_o,
  output logic [CFG_DW-1:0] cfg_wdata_o,
  input  logic [CFG_DW-1:0] cfg_rdata_i,
  input  logic              cfg_rdy_i,
  output logic              core_run_o,
  output logic              clk_en_o
);
  logic              wr_stb;
  logic [AW-1:0]     wr_addr, rd_addr;
  logic [DW-1:0]     wr_data, rd_data;
  logic              seq_busy, start, start_rd;
  logic [CFG_AW-1:0] start_addr;
  logic [CFG_DW-1:0] start_data, cap;

  cfgb_axil_port #(.AW(AW), .DW(DW)) i_port (
    .clk_i, .rst_ni,
    .s_awaddr_i, .s_awvalid_i, .s_awready_o,
    .s_wdata_i, .s_wvalid_i, .s_wready_o,
    .s_bresp_o, .s_bvalid_o, .s_bready_i,
    .s_araddr_i, .s_arvalid_i, .s_arready_o,
    .s_rdata_o, .s_rresp_o, .s_rvalid_o, .s_rready_i,
    .wr_stb_o(wr_stb), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data)
  );

  cfgb_regs #(.AW(AW), .DW(DW), .CFG_AW(CFG_AW), .CFG_DW(CFG_DW)) i_regs (
    .clk_i, .rst_ni,
    .wr_stb_i(wr_stb), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .busy_i(seq_busy), .cap_i(cap),
    .start_o(start), .start_rd_o(start_rd),
    .start_addr_o(start_addr), .start_data_o(start_data),
    .core_run_o, .clk_en_o
  );

  cfgb_seq #(.CFG_AW(CFG_AW), .CFG_DW(CFG_DW)) i_seq (
    .clk_i, .rst_ni,
    .start_i(start), .start_rd_i(start_rd),
    .start_addr_i(start_addr), .start_data_i(start_data),
    .cfg_en_o, .cfg_we_o, .cfg_addr_o, .cfg_wdata_o,
    .cfg_rdata_i, .cfg_rdy_i,
    .busy_o(seq_busy), .cap_o(cap)
  );
endmodule

// File: rtl/cfg_port_bridge_chk.sv
module cfg_port_bridge_chk #(
  parameter int CFG_AW = 7,
  parameter int DW     = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_en_i,
  input logic              cfg_we_i,
  input logic [CFG_AW-1:0] cfg_addr_i,
  input logic              cfg_rdy_i,
  input logic              busy_i,
  input logic              bvalid_i,
  input logic              bready_i,
  input logic              rvalid_i,
  input logic              rready_i,
  input logic [DW-1:0]     rdata_i
);
  a_r10_en_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_en_i |=> !cfg_en_i);
  a_r10_we_only_with_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |-> cfg_en_i);
  a_r3_en_sets_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_en_i |-> busy_i);
  a_r3_rdy_clears_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && cfg_rdy_i |=> !busy_i);
  a_r5_busy_rise_has_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> cfg_en_i);
  a_r10_addr_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && !cfg_en_i |-> $stable(cfg_addr_i));
  a_r9_bvalid_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bvalid_i && !bready_i |=> bvalid_i);
  a_r9_rvalid_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_i && !rready_i |=> rvalid_i && $stable(rdata_i));
endmodule

bind cfg_port_bridge cfg_port_bridge_chk #(.CFG_AW(CFG_AW), .DW(DW)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .cfg_en_i(cfg_en_o), .cfg_we_i(cfg_we_o), .cfg_addr_i(cfg_addr_o),
  .cfg_rdy_i(cfg_rdy_i), .busy_i(seq_busy),
  .bvalid_i(s_bvalid_o), .bready_i(s_bready_i),
  .rvalid_i(s_rvalid_o), .rready_i(s_rready_i), .rdata_i(s_rdata_o)
);

// File: tb/test_cfg_port_bridge.sv
`timescale 1ns/1ps
module test_cfg_port_bridge;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  s_awaddr_i = '0;
  logic        s_awvalid_i = 1'b0;
  logic        s_awready_o;
  logic [31:0] s_wdata_i = '0;
  logic        s_wvalid_i = 1'b0;
  logic        s_wready_o;
  logic [1:0]  s_bresp_o;
  logic        s_bvalid_o;
  logic        s_bready_i = 1'b0;
  logic [7:0]  s_araddr_i = '0;
  logic        s_arvalid_i = 1'b0;
  logic        s_arready_o;
  logic [31:0] s_rdata_o;
  logic [1:0]  s_rresp_o;
  logic        s_rvalid_o;
  logic        s_rready_i = 1'b1;
  logic        cfg_en_o, cfg_we_o;
  logic [6:0]  cfg_addr_o;
  logic [15:0] cfg_wdata_o;
  logic [15:0] cfg_rdata_i = '0;
  logic        cfg_rdy_i = 1'b0;
  logic        core_run_o, clk_en_o;

  cfg_port_bridge i_cfg_port_bridge (.*);

  always #4 clk_i = ~clk_i;

  int vecs = 0, errs = 0, cyc = 0;
  bit done = 0;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vecs++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // configuration-port responder
  logic [15:0] mem [int];
  int lat = 2, rcnt = 0;
  logic [6:0] raddr;
  bit rwr;
  always @(posedge clk_i) begin
    #1;
    cfg_rdy_i = 1'b0;
    if (cfg_en_o) begin
      rcnt = lat; raddr = cfg_addr_o; rwr = cfg_we_o;
      if (cfg_we_o) mem[int'(cfg_addr_o)] = cfg_wdata_o;
    end else if (rcnt > 0) begin
      rcnt--;
      if (rcnt == 0) begin
        cfg_rdy_i = 1'b1;
        cfg_rdata_i = rwr ? 16'h0000 : (mem.exists(int'(raddr)) ? mem[int'(raddr)] : 16'hDEAD);
      end
    end
  end

  // behavioural reference model
  bit m_bvalid, m_rvalid, m_en, m_we, m_busy, m_rd, m_run, m_clken;
  logic [31:0] m_rdata;
  logic [6:0]  m_addr;
  logic [15:0] m_wdata, m_cap;
  bit wacc, racc, start;
  logic [31:0] nrd;

  function automatic logic [31:0] m_read(input logic [7:0] a);
    int w = int'(a) / 4;
    if (w == 'h40 / 4) return {30'd0, m_clken, m_run};
    if (w == 'h74 / 4) return {15'd0, m_busy, m_cap};
    return 32'd0;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_bvalid = 0; m_rvalid = 0; m_en = 0; m_we = 0; m_busy = 0; m_rd = 0;
      m_run = 0; m_clken = 0; m_rdata = '0; m_addr = '0; m_wdata = '0; m_cap = '0;
    end else begin
      wacc  = s_awvalid_i && s_wvalid_i && !m_bvalid;
      racc  = s_arvalid_i && !m_rvalid;
      nrd   = m_read(s_araddr_i);
      start = wacc && (int'(s_awaddr_i) / 4 == 'h70 / 4) && s_wdata_i[29] && !m_busy;
      if (racc) begin m_rvalid = 1; m_rdata = nrd; end
      else if (s_rready_i) m_rvalid = 0;
      if (m_busy && cfg_rdy_i) begin
        m_busy = 0;
        if (m_rd) m_cap = cfg_rdata_i;
      end
      m_en = 0; m_we = 0;
      if (start) begin
        m_busy = 1; m_en = 1; m_we = !s_wdata_i[28]; m_rd = s_wdata_i[28];
        m_addr = s_wdata_i[22:16]; m_wdata = s_wdata_i[15:0];
      end
      if (wacc && int'(s_awaddr_i) / 4 == 'h40 / 4) begin
        m_run = s_wdata_i[0]; m_clken = s_wdata_i[1];
      end
      if (wacc) m_bvalid = 1;
      else if (s_bready_i) m_bvalid = 0;
    end
  end

  always @(negedge clk_i) if (!done) begin
    check("R9 awready", 32'(s_awready_o), 32'(!m_bvalid && s_awvalid_i && s_wvalid_i));
    check("R9 wready",  32'(s_wready_o),  32'(!m_bvalid && s_awvalid_i && s_wvalid_i));
    check("R9 bvalid",  32'(s_bvalid_o),  32'(m_bvalid));
    check("R9 bresp",   32'(s_bresp_o),   32'd0);
    check("R9 arready", 32'(s_arready_o), 32'(!m_rvalid));
    check("R9 rvalid",  32'(s_rvalid_o),  32'(m_rvalid));
    check("R9 rresp",   32'(s_rresp_o),   32'd0);
    check("R1 R3 R4 R7 R8 rdata", s_rdata_o, m_rdata);
    check("R2 R5 R6 R10 cfg_en", 32'(cfg_en_o), 32'(m_en));
    check("R2 R10 cfg_we", 32'(cfg_we_o), 32'(m_we));
    check("R2 R5 cfg_addr", 32'(cfg_addr_o), 32'(m_addr));
    check("R2 R5 cfg_wdata", 32'(cfg_wdata_o), 32'(m_wdata));
    check("R7 core_run", 32'(core_run_o), 32'(m_run));
    check("R7 clk_en", 32'(clk_en_o), 32'(m_clken));
  end

  task automatic axil_write(input logic [7:0] a, input logic [31:0] d, input int hold = 0);
    @(posedge clk_i); #1;
    s_awaddr_i = a; s_wdata_i = d; s_awvalid_i = 1; s_wvalid_i = 1; s_bready_i = 0;
    @(negedge clk_i);
    while (!s_awready_o) @(negedge clk_i);
    @(posedge clk_i); #1;
    s_awvalid_i = 0; s_wvalid_i = 0;
    @(negedge clk_i);
    while (!s_bvalid_o) @(negedge clk_i);
    repeat (hold) begin
      @(negedge clk_i);
      check("R9 bvalid held", 32'(s_bvalid_o), 32'd1);
    end
    @(posedge clk_i); #1; s_bready_i = 1;
    @(posedge clk_i); #1; s_bready_i = 0;
  endtask

  task automatic axil_read(input logic [7:0] a, output logic [31:0] d);
    @(posedge clk_i); #1;
    s_araddr_i = a; s_arvalid_i = 1;
    @(negedge clk_i);
    while (!s_arready_o) @(negedge clk_i);
    @(posedge clk_i); #1;
    s_arvalid_i = 0;
    @(negedge clk_i);
    while (!s_rvalid_o) @(negedge clk_i);
    d = s_rdata_o;
  endtask

  task automatic wait_idle(output logic [31:0] st);
    int n = 0;
    do begin axil_read(8'h74, st); n++; end while (st[16] && n < 500);
  endtask

  task automatic cfg_wr(input logic [6:0] a, input logic [15:0] d);
    logic [31:0] st;
    axil_write(8'h70, (32'd1 << 29) | (32'(a) << 16) | 32'(d));
    wait_idle(st);
  endtask

  task automatic cfg_rd(input logic [6:0] a, output logic [15:0] d);
    logic [31:0] st;
    axil_write(8'h70, (32'd3 << 28) | (32'(a) << 16));
    wait_idle(st);
    d = st[15:0];
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc == 100000 && !done) begin
      errs++;
      $display("FAIL R9 watchdog: got hang expected completion");
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [15:0] d;
    logic [6:0]  addrs [9] = '{7'h08, 7'h09, 7'h14, 7'h15, 7'h16, 7'h18, 7'h19, 7'h1a, 7'h4f};
    logic [15:0] vals  [9];
    repeat (3) @(negedge clk_i);
    check("R1 core_run in reset", 32'(core_run_o), 32'd0);
    check("R1 cfg_en in reset", 32'(cfg_en_o), 32'd0);
    rst_ni = 1'b1;
    axil_read(8'h40, r); check("R1 reset reg", r, 32'd0);
    axil_read(8'h74, r); check("R1 status", r, 32'd0);

    axil_write(8'h40, 32'h1);
    axil_read(8'h40, r); check("R7 run only", r, 32'h1);
    check("R7 clk_en off", 32'(clk_en_o), 32'd0);
    axil_write(8'h40, 32'h3);
    axil_read(8'h40, r); check("R7 both", r, 32'h3);
    axil_write(8'h42, 32'hFFFF_FFFC);
    axil_read(8'h40, r); check("R7 R8 low bits ignored", r, 32'h0);

    cfg_wr(7'h14, 16'hBEEF);
    check("R2 write reached port", 32'(mem[32'h14]), 32'hBEEF);
    axil_read(8'h74, r); check("R4 write leaves capture", r, 32'h0);
    axil_write(8'h70, (32'd3 << 28) | (32'd1 << 23) | (32'h14 << 16) | 32'h1234);
    wait_idle(r); check("R4 R2 read with stray bits", r, 32'h0000_BEEF);

    foreach (addrs[i]) begin
      vals[i] = 16'h1000 + 16'(i) * 16'h0111;
      lat = 1 + (i % 3);
      cfg_wr(addrs[i], vals[i]);
    end
    foreach (addrs[i]) begin
      lat = 3 - (i % 3);
      cfg_rd(addrs[i], d);
      check("R4 readback", 32'(d), 32'(vals[i]));
    end

    lat = 20;
    axil_write(8'h70, (32'd1 << 29) | (32'h4e << 16) | 32'h1111);
    axil_write(8'h70, (32'd1 << 29) | (32'h4f << 16) | 32'h2222);
    axil_read(8'h74, r); check("R3 busy seen", 32'(r[16]), 32'd1);
    wait_idle(r); check("R3 busy cleared", 32'(r[16]), 32'd0);
    lat = 2;
    cfg_rd(7'h4e, d); check("R5 first write landed", 32'(d), 32'h1111);
    cfg_rd(7'h4f, d); check("R5 busy write ignored", 32'(d), 32'(vals[8]));

    axil_write(8'h70, (32'h08 << 16) | 32'h7777);
    repeat (5) @(posedge clk_i);
    cfg_rd(7'h08, d); check("R6 select clear ignored", 32'(d), 32'(vals[0]));
    cfg_rd(7'h33, d); check("R4 unwritten register", 32'(d), 32'hDEAD);

    axil_write(8'h40, 32'h1);
    axil_write(8'h44, 32'hFFFF_FFFF);
    axil_write(8'h74, 32'hFFFF_FFFF);
    axil_read(8'h40, r); check("R8 unmapped write", r, 32'h1);
    axil_read(8'h74, r); check("R8 status write ignored", r, 32'h0000_DEAD);
    axil_read(8'h00, r); check("R8 offset 0x00", r, 32'h0);
    axil_read(8'h44, r); check("R8 offset 0x44", r, 32'h0);
    axil_read(8'h70, r); check("R8 control reads zero", r, 32'h0);
    axil_read(8'hFC, r); check("R8 offset 0xFC", r, 32'h0);

    axil_write(8'h40, 32'h2, 3);
    axil_read(8'h40, r); check("R9 R7 held response", r, 32'h2);

    repeat (4) @(posedge clk_i);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule